// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block moves the bits of a WIDTH-bit operand by an immediate count. It supports three shifts, two plain rotates, and two rotates that run through the carry flag. The carry flag takes part in every operation. After a shift it holds the last bit pushed out. After a plain rotate it holds a copy of the last bit that wrapped around. In a rotate through carry, the flag and the operand together form one ring of WIDTH+1 bits.

A requester presents the operand, a count, a three-bit operation code and the current carry, and raises `inValid` for one cycle. With the default `REG_OUT = 1`, the result, the new carry and the negative and zero flags appear in registers on the next clock edge, and `outValid` pulses high for that cycle. The outputs keep their values until the next accepted request. With `REG_OUT = 0`, the outputs follow the inputs combinationally and `outValid` follows `inValid`.

The count port is one bit wider than needed to name a bit position. The block reduces the count modulo WIDTH before it uses it.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation code 3'b000 shifts left: zeros enter at bit 0, and carryOut is the last bit that left the top bit.
- R2: Operation code 3'b001 shifts right logically: zeros enter at the top bit, and carryOut is the last bit that left bit 0.
- R3: Operation code 3'b010 shifts right arithmetically: every vacated upper bit copies the original top bit, and carryOut is the last bit that left bit 0.
- R4: Operation code 3'b011 rotates left and 3'b100 rotates right, with no bit lost. carryOut is a copy of the last bit that wrapped: after a left rotate this equals the new bit 0, and after a right rotate it equals the new top bit.
- R5: Operation code 3'b101 rotates left and 3'b110 rotates right through carry, over the ring {carry, operand}. The old carryIn enters the vacated end, and the bit leaving the operand becomes carryOut.
- R6: Operation code 3'b111 returns the operand unchanged, with carryOut equal to carryIn.
- R7: When the reduced count is zero, every operation returns the operand unchanged, with carryOut equal to carryIn.
- R8: A count of WIDTH or more behaves exactly like that count modulo WIDTH.
- R9: negFlag equals the top bit of result, and zeroFlag is 1 exactly when result is all zeros.
- R10: With `REG_OUT = 1`, a request with inValid high updates the outputs on the next rising edge and raises outValid for that one cycle. While inValid is low, outValid is 0 and result, carryOut and the flags hold their values.
- R11: While rst_n is low, outValid, result, carryOut and negFlag are 0, and zeroFlag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe; the inputs are taken in this cycle |
| operand | input | WIDTH | Value to shift or rotate |
| count | input | COUNT_W | Immediate shift count, reduced modulo WIDTH |
| opSel | input | 3 | Operation code (see R1 to R6) |
| carryIn | input | 1 | Current carry flag |
| outValid | output | 1 | High for the cycle in which a new result is presented |
| result | output | WIDTH | Shifted or rotated value |
| carryOut | output | 1 | New carry flag |
| negFlag | output | 1 | Top bit of result |
| zeroFlag | output | 1 | Result is all zeros |

## Verification
Two behaviours can apply to the same request.

- **Modulo reduction and zero-count pass-through.** A count equal to WIDTH reduces to zero, so the pass-through rule must then win over the selected operation. The bench sweeps every count from 0 to 2*WIDTH-1, for every operation code, both carry values and all operands. For counts of WIDTH and above it expects exactly the result of the reduced count, so count WIDTH must return the operand and carryIn untouched.
- **Carry ring and count.** In a rotate through carry, the incoming carry and the count both affect the outcome. The bench computes each expected value by stepping a one-bit model the reduced number of times and compares it with result, carryOut and both flags.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    OP_SHL  = 3'b000,
    OP_SHR  = 3'b001,
    OP_SAR  = 3'b010,
    OP_ROTL = 3'b011,
    OP_ROTR = 3'b100,
    OP_RCL  = 3'b101,
    OP_RCR  = 3'b110,
    OP_PASS = 3'b111
  } op_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic selShl;
    logic selShr;
    logic selSar;
    logic selRotl;
    logic selRotr;
    logic selRcl;
    logic selRcr;
    logic selPass;
    logic cntZero;
    logic load;
  } strobe_t;

endpackage

// File: rtl/shrot_ctrl.sv
module shrot_ctrl #(
  parameter int WIDTH   = 8,
  parameter int COUNT_W = $clog2(WIDTH) + 1,
  parameter bit REG_OUT = 1'b1,
  localparam int SHAMT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inValid,
  input  logic [2:0]               opSel,
  input  logic [COUNT_W-1:0]       count,
  output shrot_pkg::strobe_t       strb,
  output logic [SHAMT_W-1:0]       shamt,
  output logic                     outValid
);
  import shrot_pkg::*;

  op_e opCode;

  // Count reduction (R8)
  always_comb begin
    shamt = SHAMT_W'(int'(count) % WIDTH);
  end

  // Operation decode into strobes
  always_comb begin
    opCode = op_e'(opSel);
    strb   = '0;
    unique case (opCode)
      OP_SHL:  strb.selShl  = 1'b1;
      OP_SHR:  strb.selShr  = 1'b1;
      OP_SAR:  strb.selSar  = 1'b1;
      OP_ROTL: strb.selRotl = 1'b1;
      OP_ROTR: strb.selRotr = 1'b1;
      OP_RCL:  strb.selRcl  = 1'b1;
      OP_RCR:  strb.selRcr  = 1'b1;
      default: strb.selPass = 1'b1;
    endcase
    strb.cntZero = (shamt == '0);
    strb.load    = inValid;
  end

  generate
    if (REG_OUT) begin : g_vreg
      logic validQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) validQ <= 1'b0;
        else        validQ <= inValid;
      end
      assign outValid = validQ;

      assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        inValid |=> outValid);
      assert_valid_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !inValid |=> !outValid);
    end else begin : g_vcomb
      assign outValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/shrot_dpath.sv
module shrot_dpath #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int SHAMT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  shrot_pkg::strobe_t   strb,
  input  logic [SHAMT_W-1:0]   shamt,
  input  logic [WIDTH-1:0]     operand,
  input  logic                 carryIn,
  output logic [WIDTH-1:0]     result,
  output logic                 carryOut,
  output logic                 negFlag,
  output logic                 zeroFlag
);

  logic [WIDTH:0]          shlExt;
  logic [WIDTH:0]          shrExt;
  logic signed [WIDTH:0]   sarExt;
  logic [WIDTH-1:0]        rotlVal;
  logic [WIDTH-1:0]        rotrVal;
  logic [WIDTH:0]          ring;
  logic [WIDTH:0]          rclRing;
  logic [WIDTH:0]          rcrRing;
  logic [WIDTH-1:0]        nextRes;
  logic                    nextCarry;
  logic                    nextNeg;
  logic                    nextZero;

  // Candidate results
  always_comb begin
    shlExt  = {1'b0, operand} << shamt;
    shrExt  = {operand, 1'b0} >> shamt;
    sarExt  = $signed({operand, 1'b0}) >>> shamt;
    rotlVal = (operand << shamt) | (operand >> (WIDTH - int'(shamt)));
    rotrVal = (operand >> shamt) | (operand << (WIDTH - int'(shamt)));
    ring    = {carryIn, operand};
    rclRing = (ring << shamt) | (ring >> (WIDTH + 1 - int'(shamt)));
    rcrRing = (ring >> shamt) | (ring << (WIDTH + 1 - int'(shamt)));
  end

  // Select by strobe; a zero count keeps operand and carry
  always_comb begin
    nextRes   = operand;
    nextCarry = carryIn;
    if (!strb.cntZero) begin
      if (strb.selShl) begin
        nextRes   = shlExt[WIDTH-1:0];
        nextCarry = shlExt[WIDTH];
      end else if (strb.selShr) begin
        nextRes   = shrExt[WIDTH:1];
        nextCarry = shrExt[0];
      end else if (strb.selSar) begin
        nextRes   = sarExt[WIDTH:1];
        nextCarry = sarExt[0];
      end else if (strb.selRotl) begin
        nextRes   = rotlVal;
        nextCarry = rotlVal[0];
      end else if (strb.selRotr) begin
        nextRes   = rotrVal;
        nextCarry = rotrVal[WIDTH-1];
      end else if (strb.selRcl) begin
        nextRes   = rclRing[WIDTH-1:0];
        nextCarry = rclRing[WIDTH];
      end else if (strb.selRcr) begin
        nextRes   = rcrRing[WIDTH-1:0];
        nextCarry = rcrRing[WIDTH];
      end
    end
    nextNeg  = nextRes[WIDTH-1];
    nextZero = (nextRes == '0);
  end

  generate
    if (REG_OUT) begin : g_oreg
      logic [WIDTH-1:0] resQ;
      logic             carryQ;
      logic             negQ;
      logic             zeroQ;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          resQ   <= '0;
          carryQ <= 1'b0;
          negQ   <= 1'b0;
          zeroQ  <= 1'b1;
        end else if (strb.load) begin
          resQ   <= nextRes;
          carryQ <= nextCarry;
          negQ   <= nextNeg;
          zeroQ  <= nextZero;
        end
      end

      assign result   = resQ;
      assign carryOut = carryQ;
      assign negFlag  = negQ;
      assign zeroFlag = zeroQ;

      assert_shl_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.load && strb.selShl && !strb.cntZero) |=> !resQ[0]);
      assert_sar_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.load && strb.selSar) |=> (resQ[WIDTH-1] == $past(operand[WIDTH-1])));
      assert_rot_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.load && (strb.selRotl || strb.selRotr))
          |=> ($countones(resQ) == $countones($past(operand))));
      assert_ring_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.load && (strb.selRcl || strb.selRcr))
          |=> ($countones({carryQ, resQ}) == $countones({$past(carryIn), $past(operand)})));
      assert_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.load && strb.selPass)
          |=> (resQ == $past(operand) && carryQ == $past(carryIn)));
      assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.load && strb.cntZero)
          |=> (resQ == $past(operand) && carryQ == $past(carryIn)));
      assert_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (negQ == resQ[WIDTH-1]) && (zeroQ == (resQ == '0)));
      assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !strb.load |=> ($stable(resQ) && $stable(carryQ) && $stable(zeroQ)));
    end else begin : g_ocomb
      assign result   = nextRes;
      assign carryOut = nextCarry;
      assign negFlag  = nextNeg;
      assign zeroFlag = nextZero;
    end
  endgenerate

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit #(
  parameter int WIDTH   = 8,
  parameter int COUNT_W = $clog2(WIDTH) + 1,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic [WIDTH-1:0]   operand,
  input  logic [COUNT_W-1:0] count,
  input  logic [2:0]         opSel,
  input  logic               carryIn,
  output logic               outValid,
  output logic [WIDTH-1:0]   result,
  output logic               carryOut,
  output logic               negFlag,
  output logic               zeroFlag
);

  localparam int SHAMT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  shrot_pkg::strobe_t strb;
  logic [SHAMT_W-1:0] shamt;

  shrot_ctrl #(
    .WIDTH   (WIDTH),
    .COUNT_W (COUNT_W),
    .REG_OUT (REG_OUT)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .opSel    (opSel),
    .count    (count),
    .strb     (strb),
    .shamt    (shamt),
    .outValid (outValid)
  );

  shrot_dpath #(
    .WIDTH   (WIDTH),
    .REG_OUT (REG_OUT)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .shamt    (shamt),
    .operand  (operand),
    .carryIn  (carryIn),
    .result   (result),
    .carryOut (carryOut),
    .negFlag  (negFlag),
    .zeroFlag (zeroFlag)
  );

endmodule

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] operand = '0;
  logic [3:0] count = '0;
  logic [2:0] opSel = '0;
  logic       carryIn = 1'b0;
  logic       outValid;
  logic [7:0] result;
  logic       carryOut;
  logic       negFlag;
  logic       zeroFlag;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  shift_rotate_unit #(.WIDTH(8), .COUNT_W(4), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .operand(operand),
    .count(count), .opSel(opSel), .carryIn(carryIn), .outValid(outValid),
    .result(result), .carryOut(carryOut), .negFlag(negFlag), .zeroFlag(zeroFlag)
  );

  // Bit-serial reference: returns {carry, value}
  function automatic logic [8:0] refModel(input logic [2:0] op, input int cnt,
                                          input logic cin, input logic [7:0] v);
    logic [7:0] r = v;
    logic       c = cin;
    logic       t;
    for (int i = 0; i < cnt % 8; i++) begin
      case (op)
        3'd0: begin c = r[7]; r = {r[6:0], 1'b0}; end
        3'd1: begin c = r[0]; r = {1'b0, r[7:1]}; end
        3'd2: begin c = r[0]; r = {r[7], r[7:1]}; end
        3'd3: begin c = r[7]; r = {r[6:0], r[7]}; end
        3'd4: begin c = r[0]; r = {r[0], r[7:1]}; end
        3'd5: begin t = r[7]; r = {r[6:0], c}; c = t; end
        3'd6: begin t = r[0]; r = {c, r[7:1]}; c = t; end
        default: ;
      endcase
    end
    return {c, r};
  endfunction

  function automatic string tagFor(input logic [2:0] op, input int cnt);
    if (cnt >= 8) return "R8";
    if (cnt == 0) return "R7";
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3, 3'd4: return "R4";
      3'd5, 3'd6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 100000, 0);
    summary();
    $finish;
  end

  initial begin
    logic [8:0] exp;
    logic [7:0] heldRes;
    logic       heldC;
    logic       heldZ;

    // R11: state while in reset
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && result == 8'h00 && carryOut == 1'b0,
          "R11 reset outputs", {2'b0, outValid, carryOut, result}, 11'h0);
    check(negFlag == 1'b0 && zeroFlag == 1'b1, "R11 reset flags",
          {9'b0, negFlag, zeroFlag}, 11'h1);
    rst_n = 1'b1;

    // Exhaustive sweep: operand x op x count x carry
    for (int o = 0; o < 256; o++) begin
      for (int s = 0; s < 8; s++) begin
        for (int c = 0; c < 16; c++) begin
          for (int ci = 0; ci < 2; ci++) begin
            @(negedge clk);
            operand = 8'(o);
            opSel   = 3'(s);
            count   = 4'(c);
            carryIn = 1'(ci);
            inValid = 1'b1;
            @(posedge clk);
            #1;
            exp = refModel(3'(s), c, 1'(ci), 8'(o));
            check({outValid, carryOut, result} == {1'b1, exp},
                  tagFor(3'(s), c), {2'b0, outValid, carryOut, result}, {2'b0, 1'b1, exp});
            check(negFlag == exp[7] && zeroFlag == (exp[7:0] == 8'h00), "R9 flags",
                  {9'b0, negFlag, zeroFlag}, {9'b0, exp[7], exp[7:0] == 8'h00});
          end
        end
      end
    end

    // R10: hold while no request, outValid low
    @(negedge clk);
    operand = 8'hB4; opSel = 3'd5; count = 4'd3; carryIn = 1'b1; inValid = 1'b1;
    @(posedge clk);
    #1;
    exp = refModel(3'd5, 3, 1'b1, 8'hB4);
    check({outValid, carryOut, result} == {1'b1, exp}, "R10 load",
          {2'b0, outValid, carryOut, result}, {2'b0, 1'b1, exp});
    heldRes = result; heldC = carryOut; heldZ = zeroFlag;
    for (int h = 0; h < 4; h++) begin
      @(negedge clk);
      inValid = 1'b0;
      operand = 8'(h * 37 + 1);
      opSel   = 3'(h);
      count   = 4'(h + 1);
      carryIn = ~carryIn;
      @(posedge clk);
      #1;
      check(outValid == 1'b0 && result == heldRes && carryOut == heldC && zeroFlag == heldZ,
            "R10 hold", {1'b0, zeroFlag, outValid, carryOut, result},
            {1'b0, heldZ, 1'b0, heldC, heldRes});
    end

    summary();
    $finish;
  end

endmodule